// File: doc/BRIEF.md
# Double-Buffered PWM Generator with Fault Shutdown

This block turns an external period timer into a pulse-width modulated output. The timer and its prescaler sit outside the block. The block receives the running count and a strobe that marks the cycle in which the count reaches the period value, so each PWM period lasts (period value + 1) timer ticks. Software writes a new duty value into a buffer register at any moment. The value moves into the active duty register only at a period boundary, so a period never sees a half-applied update. The active duty is visible on an output.

Two mode codes enable the generator: one runs plain PWM and the other also watches an active-low fault input. While that input is low in the guarded mode, the output is forced low at once, through a combinational path that needs no clock edge. A fault status bit is also latched and an interrupt pulse is raised. The status bit and the shutdown remain in force until software writes the mode field again. A channel-index parameter picks which of two fault pins the instance listens to. An idle-stop control decides whether the generator freezes or keeps running while the system idles.

Top module: `pwm_fault_gen`

## Requirements
- R1: Only mode 3'b110 (plain PWM) and mode 3'b111 (PWM with fault guard) enable the generator. With any other mode value, `pwm_o` is low, `irq_o` stays low and `duty_active` is not loaded.
- R2: A write to the duty buffer may happen at any time. `duty_active` takes the buffered value only at a clock edge where `period_match` is high, and it keeps its old value for the rest of the current period.
- R3: In each period, `pwm_o` is high from the first cycle of the period (count 0) for exactly `duty_active` cycles, and then low until the period ends.
- R4: When `duty_active` is 0, `pwm_o` stays low for the whole period.
- R5: When `duty_active` is greater than the period value, `pwm_o` stays high for the whole period.
- R6: `irq_o` is a one-cycle pulse in the first cycle of every period, that is, the cycle after each `period_match`.
- R7: In mode 3'b111, a low level on the selected fault pin drives `pwm_o` low in the same cycle, before any clock edge. At the next edge, `fault_sts` is set and `irq_o` pulses.
- R8: Once set, `fault_sts` stays set and `pwm_o` stays low, even after the fault pin returns high, until `mode_wr` is pulsed. After that pulse, `fault_sts` reads 0 and normal PWM resumes.
- R9: For CHAN_IDX 1 to 4 the fault pin is `flt_a_n`, and for CHAN_IDX 5 to 8 it is `flt_b_n`. The unselected fault pin has no effect, and in mode 3'b110 neither fault pin has any effect.
- R10: While `sys_idle` and `idle_stop` are both high, the generator freezes: `pwm_o` and `duty_active` hold their values and no period interrupt is raised. With `idle_stop` low, the generator runs normally during idle.
- R11: After reset, `pwm_o`, `irq_o` and `fault_sts` are 0 and `duty_active` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt | input | CNT_W | Running count of the selected period timer |
| period_match | input | 1 | High in the cycle where the count equals the period value |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | CNT_W | Value written into the duty buffer |
| mode | input | 3 | Mode field: 3'b110 plain PWM, 3'b111 PWM with fault guard |
| mode_wr | input | 1 | Pulse marking a software write of the mode field; clears the fault status |
| flt_a_n | input | 1 | Active-low fault pin A (channels 1 to 4) |
| flt_b_n | input | 1 | Active-low fault pin B (channels 5 to 8) |
| sys_idle | input | 1 | System idle indication |
| idle_stop | input | 1 | When high, freeze the generator during idle |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt pulse at each period start and on a fault |
| fault_sts | output | 1 | Latched fault status |
| duty_active | output | CNT_W | Active (read-only) duty value |

## Verification
The bench builds the block with CNT_W = 16 and CHAN_IDX = 1, so the selected fault path is pin A and pin B is the one that must be ignored. The bench's own timer uses a period value of 9. This short period brings the zero duty, the duty of exactly period + 1, a duty far above the period, and mid-period buffer writes within reach in a few hundred cycles. Fault entry is triggered in the middle of a high phase, so the same-cycle output kill can be seen apart from the registered status bit.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
   // mode field codes that enable the generator
   localparam logic [2:0] MODE_PWM_PLAIN = 3'b110;
   localparam logic [2:0] MODE_PWM_GUARD = 3'b111;
   // highest channel index served by fault pin A
   localparam int unsigned FLT_A_LAST_CHAN = 4;
endpackage

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             load,
   output logic [CNT_W-1:0] next_duty,
   output logic [CNT_W-1:0] active_duty
);
   logic [CNT_W-1:0] dbuf_q;
   logic [CNT_W-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbuf_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr_en) dbuf_q <= wr_data;
         if (load)  act_q  <= dbuf_q;
      end
   end

   assign next_duty   = dbuf_q;
   assign active_duty = act_q;

   // R2
   act_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(load));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             en,
   input  logic             period_match,
   input  logic [CNT_W-1:0] tmr_cnt,
   input  logic [CNT_W-1:0] active_duty,
   input  logic [CNT_W-1:0] next_duty,
   input  logic             fault_evt,
   output logic             pwm_q_o,
   output logic             irq_o
);
   localparam int unsigned EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] cnt_nxt;
   logic             end_hit;
   logic             pwm_q;
   logic             irq_q;

   // the cycle that holds count (duty-1) is the last high cycle
   assign cnt_nxt = {1'b0, tmr_cnt} + EXT_W'(1);
   assign end_hit = (cnt_nxt == {1'b0, active_duty});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= fault_evt | (run & en & period_match);
         if (!en) begin
            pwm_q <= 1'b0;
         end else if (run) begin
            if (period_match)  pwm_q <= (next_duty != '0);
            else if (end_hit)  pwm_q <= 1'b0;
         end
      end
   end

   assign pwm_q_o = pwm_q;
   assign irq_o   = irq_q;

   // R3
   rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q) |-> $past(period_match && run));

   // R6
   irq_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q) |-> irq_q);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
   parameter int unsigned CHAN_IDX = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flt_mode,
   input  logic mode_wr,
   input  logic flt_a_n,
   input  logic flt_b_n,
   input  logic pwm_in,
   output logic pwm_out,
   output logic fault_sts_o,
   output logic fault_evt_o
);
   import pwm_fault_pkg::*;

   localparam bit USE_PIN_B = (CHAN_IDX > FLT_A_LAST_CHAN);

   logic pin_n;
   logic fault_now;
   logic sts_q;

   generate
      if (USE_PIN_B) begin : g_pin_b
         logic unused_a;
         assign unused_a = flt_a_n;
         assign pin_n    = flt_b_n;
      end else begin : g_pin_a
         logic unused_b;
         assign unused_b = flt_b_n;
         assign pin_n    = flt_a_n;
      end
   endgenerate

   assign fault_now = flt_mode & ~pin_n;

   always_ff @(posedge clk) begin
      if (!rst_n)         sts_q <= 1'b0;
      else if (mode_wr)   sts_q <= 1'b0;
      else if (fault_now) sts_q <= 1'b1;
   end

   // immediate shutdown: the live pin level also gates the output
   assign pwm_out     = (fault_now | sts_q) ? 1'b0 : pwm_in;
   assign fault_sts_o = sts_q;
   assign fault_evt_o = fault_now & ~sts_q;

   // R7
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q) |-> ($past(flt_mode) && !$past(pin_n)));

   // R8
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q) |-> $past(mode_wr));
endmodule

// File: rtl/pwm_fault_gen.sv
module pwm_fault_gen #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned CHAN_IDX = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tmr_cnt,
   input  logic             period_match,
   input  logic             duty_wr,
   input  logic [CNT_W-1:0] duty_wdata,
   input  logic [2:0]       mode,
   input  logic             mode_wr,
   input  logic             flt_a_n,
   input  logic             flt_b_n,
   input  logic             sys_idle,
   input  logic             idle_stop,
   output logic             pwm_o,
   output logic             irq_o,
   output logic             fault_sts,
   output logic [CNT_W-1:0] duty_active
);
   import pwm_fault_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_fault_gen: CNT_W must lie in 2..32");
      end
      if (CHAN_IDX < 1 || CHAN_IDX > 8) begin : g_bad_chan
         $error("pwm_fault_gen: CHAN_IDX must lie in 1..8");
      end
   endgenerate

   logic             run;
   logic             en;
   logic             flt_mode;
   logic             load;
   logic [CNT_W-1:0] next_duty;
   logic             pwm_raw;
   logic             fault_evt;

   assign run      = ~(sys_idle & idle_stop);
   assign en       = (mode == MODE_PWM_PLAIN) || (mode == MODE_PWM_GUARD);
   assign flt_mode = (mode == MODE_PWM_GUARD);
   assign load     = run & en & period_match;

   pwm_duty_shadow #(.CNT_W(CNT_W)) shadow_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (duty_wr),
      .wr_data     (duty_wdata),
      .load        (load),
      .next_duty   (next_duty),
      .active_duty (duty_active)
   );

   pwm_edge_gen #(.CNT_W(CNT_W)) edge_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .en           (en),
      .period_match (period_match),
      .tmr_cnt      (tmr_cnt),
      .active_duty  (duty_active),
      .next_duty    (next_duty),
      .fault_evt    (fault_evt),
      .pwm_q_o      (pwm_raw),
      .irq_o        (irq_o)
   );

   pwm_fault_guard #(.CHAN_IDX(CHAN_IDX)) guard_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flt_mode    (flt_mode),
      .mode_wr     (mode_wr),
      .flt_a_n     (flt_a_n),
      .flt_b_n     (flt_b_n),
      .pwm_in      (pwm_raw),
      .pwm_out     (pwm_o),
      .fault_sts_o (fault_sts),
      .fault_evt_o (fault_evt)
   );

   // R1
   disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pwm_o);

   // R10
   idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(duty_active));
endmodule

// File: tb/pwm_fault_gen_tb.sv
`timescale 1ns/100ps
module pwm_fault_gen_tb_top;
   localparam int unsigned CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cnt = '0;
   logic [CNT_W-1:0] per = 16'd9;
   logic             period_match;
   logic             duty_wr = 1'b0;
   logic [CNT_W-1:0] duty_wdata = '0;
   logic [2:0]       mode = 3'b000;
   logic             mode_wr = 1'b0;
   logic             flt_a_n = 1'b1;
   logic             flt_b_n = 1'b1;
   logic             sys_idle = 1'b0;
   logic             idle_stop = 1'b0;
   logic             pwm_o;
   logic             irq_o;
   logic             fault_sts;
   logic [CNT_W-1:0] duty_active;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   // free-running period timer model, count 0..per
   assign period_match = (cnt == per);
   always @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt == per)   cnt <= '0;
      else                   cnt <= cnt + 16'd1;
   end

   pwm_fault_gen #(.CNT_W(CNT_W), .CHAN_IDX(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tmr_cnt(cnt), .period_match(period_match),
      .duty_wr(duty_wr), .duty_wdata(duty_wdata), .mode(mode), .mode_wr(mode_wr),
      .flt_a_n(flt_a_n), .flt_b_n(flt_b_n), .sys_idle(sys_idle),
      .idle_stop(idle_stop), .pwm_o(pwm_o), .irq_o(irq_o),
      .fault_sts(fault_sts), .duty_active(duty_active)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_duty(input int v);
      @(negedge clk);
      duty_wr = 1'b1; duty_wdata = CNT_W'(v);
      @(negedge clk);
      duty_wr = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode = m; mode_wr = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   // measure one whole period starting at count 0
   task automatic measure(output int hi, output int irqs, output int irq_first);
      hi = 0; irqs = 0; irq_first = 0;
      @(negedge clk);
      while (cnt != 0) @(negedge clk);
      for (int i = 0; i <= int'(per); i++) begin
         hi   += int'(pwm_o);
         irqs += int'(irq_o);
         if (i == 0) irq_first = int'(irq_o);
         @(negedge clk);
      end
   endtask

   task automatic apply(input int v);
      int h, q, f;
      write_duty(v);
      measure(h, q, f);
   endtask

   task automatic t_reset();
      int h, q, f;
      chk("R11 pwm_o after reset", int'(pwm_o), 0);
      chk("R11 irq_o after reset", int'(irq_o), 0);
      chk("R11 fault_sts after reset", int'(fault_sts), 0);
      chk("R11 duty_active after reset", int'(duty_active), 0);
      write_duty(5);
      measure(h, q, f);
      measure(h, q, f);
      chk("R1 mode 000 high cycles", h, 0);
      chk("R1 mode 000 irq pulses", q, 0);
      chk("R1 mode 000 no duty load", int'(duty_active), 0);
   endtask

   task automatic t_basic();
      int h, q, f;
      set_mode(3'b110);
      apply(4);
      measure(h, q, f);
      chk("R3 duty 4 high cycles", h, 4);
      chk("R6 irq pulses per period", q, 1);
      chk("R6 irq in first cycle", f, 1);
      chk("R2 duty_active loaded", int'(duty_active), 4);
      apply(7);
      measure(h, q, f);
      chk("R3 duty 7 high cycles", h, 7);
      apply(1);
      measure(h, q, f);
      chk("R3 duty 1 high cycles", h, 1);
   endtask

   task automatic t_corners();
      int h, q, f;
      apply(0);
      measure(h, q, f);
      chk("R4 duty 0 high cycles", h, 0);
      chk("R6 irq with duty 0", q, 1);
      apply(int'(per) + 1);
      measure(h, q, f);
      chk("R5 duty per+1 high cycles", h, int'(per) + 1);
      apply(200);
      measure(h, q, f);
      chk("R5 duty 200 high cycles", h, int'(per) + 1);
      apply(int'(per));
      measure(h, q, f);
      chk("R3 duty equal to period value", h, int'(per));
   endtask

   task automatic t_shadow();
      int h, q, f;
      apply(6);
      h = 0;
      @(negedge clk);
      while (cnt != 0) @(negedge clk);
      for (int i = 0; i <= int'(per); i++) begin
         h += int'(pwm_o);
         if (i == 3) begin duty_wr = 1'b1; duty_wdata = 16'd2; end
         if (i == 4) duty_wr = 1'b0;
         if (i == 6) chk("R2 duty_active held mid-period", int'(duty_active), 6);
         @(negedge clk);
      end
      chk("R2 old duty for current period", h, 6);
      measure(h, q, f);
      chk("R2 new duty next period", h, 2);
      chk("R2 duty_active after boundary", int'(duty_active), 2);
   endtask

   task automatic t_fault();
      int h, q, f;
      set_mode(3'b111);
      apply(8);
      @(negedge clk);
      while (cnt != 2) @(negedge clk);
      chk("R7 pwm high before fault", int'(pwm_o), 1);
      flt_a_n = 1'b0;
      #1;
      chk("R7 pwm killed same cycle", int'(pwm_o), 0);
      chk("R7 status not yet set", int'(fault_sts), 0);
      @(negedge clk);
      chk("R7 status set", int'(fault_sts), 1);
      chk("R7 fault irq", int'(irq_o), 1);
      flt_a_n = 1'b1;
      measure(h, q, f);
      chk("R8 output held off", h, 0);
      chk("R8 status held", int'(fault_sts), 1);
      set_mode(3'b111);
      chk("R8 status cleared by mode write", int'(fault_sts), 0);
      measure(h, q, f);
      measure(h, q, f);
      chk("R8 PWM resumed", h, 8);
   endtask

   task automatic t_chan();
      int h, q, f;
      flt_b_n = 1'b0;
      measure(h, q, f);
      chk("R9 pin B ignored on channel 1", h, 8);
      chk("R9 pin B sets no status", int'(fault_sts), 0);
      flt_b_n = 1'b1;
      set_mode(3'b110);
      flt_a_n = 1'b0;
      measure(h, q, f);
      measure(h, q, f);
      chk("R9 pin A ignored in mode 110", h, 8);
      chk("R9 mode 110 sets no status", int'(fault_sts), 0);
      flt_a_n = 1'b1;
   endtask

   task automatic t_idle();
      int h, q, f, changes, irqs;
      logic lvl;
      sys_idle = 1'b1; idle_stop = 1'b0;
      measure(h, q, f);
      chk("R10 runs during idle when idle_stop low", h, 8);
      @(negedge clk);
      while (cnt != 3) @(negedge clk);
      idle_stop = 1'b1;
      duty_wr = 1'b1; duty_wdata = 16'd3;
      @(negedge clk);
      duty_wr = 1'b0;
      lvl = pwm_o; changes = 0; irqs = 0;
      for (int i = 0; i < 2 * (int'(per) + 1); i++) begin
         if (pwm_o != lvl) changes++;
         irqs += int'(irq_o);
         @(negedge clk);
      end
      chk("R10 pwm frozen", changes, 0);
      chk("R10 no irq while frozen", irqs, 0);
      chk("R10 duty_active frozen", int'(duty_active), 8);
      sys_idle = 1'b0; idle_stop = 1'b0;
      measure(h, q, f);
      measure(h, q, f);
      chk("R10 buffered duty applied after resume", h, 3);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_corners();
      t_shadow();
      t_fault();
      t_chan();
      t_idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule